// File: doc/BRIEF.md
# Multi-Channel Down-Counting Event Timer

This block is a memory-mapped timer with a parameterised number of identical channels. All channels run from one clock. Each channel holds a 64-bit interval value and a 64-bit down-counter. Software sees both as a low and a high 32-bit word. A per-channel power-of-two prescaler sets how often the counter steps. When a step finds the counter at zero, the channel expires. In periodic mode it then reloads the interval and keeps running. In one-shot mode it parks at zero until software reloads it.

Each expiry latches a per-channel pending flag. Software clears a flag by writing one to its bit. A per-channel mask selects which pending flags drive the single interrupt output. Changes to a channel's run bit pass through a two-stage synchroniser before they gate the counter. Software must therefore allow a short delay before it treats a disabled channel as frozen. A channel loaded with an all-ones low word gives a free-running time base that software can read back as a decrementing count.

Top module: `hs_down_timer`

## Requirements
- R1: After reset every register reads zero and `irq_o` is low.
- R2: Registers are word addressed. Interrupt mask is at 0x00 and pending flags are at 0x04, with channel n at bit n in both. Channel n's control word is at 0x10+0x20*n. Its interval low and high words are at +0x04 and +0x08, and its counter low and high words are at +0x0C and +0x10. Control bits: bit 0 run, bit 1 reload, bits 6:4 prescaler select, bit 7 one-shot. The control word reads back run, prescaler and one-shot, and bit 1 always reads 0.
- R3: A control write with bit 1 set copies the full 64-bit interval into the counter on that write's clock edge. This happens whatever the run bit is, and it releases a parked one-shot channel.
- R4: Setting the run bit takes effect through a 2-stage synchroniser. After a write that sets run on edge k, the first decrement happens on edge k+3. After a write that clears run on edge d, the counter still steps on edges d, d+1 and d+2, and never after that.
- R5: The counter decrements by one per step across all 64 bits, borrowing from the high word into the low word.
- R6: A prescaler select p makes the counter step once every 2^p clocks while running, for p from 0 to 7.
- R7: In periodic mode (bit 7 = 0), a step that finds the counter at zero reloads the interval. The period is therefore interval+1 steps.
- R8: In one-shot mode (bit 7 = 1), a step that finds the counter at zero leaves it at zero. The channel then stays stopped and raises no further expiries until a reload write.
- R9: Each expiry sets the channel's pending flag whatever the mask says. Writing 1 to a flag bit clears it, writing 0 leaves it unchanged, and an expiry in the same cycle as a clear wins.
- R10: `irq_o` is high exactly when some channel has both its pending flag and its mask bit set.
- R11: With the interval low word all ones, the high word zero, and prescaler 0, consecutive reads of a running counter's low word differ by exactly one per clock.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bus and timer clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr_i | input | ADDR_W | Byte address of the register accessed |
| bus_we_i | input | 1 | Write strobe, one clock per write |
| bus_wdata_i | input | 32 | Write data |
| bus_rdata_o | output | 32 | Read data, combinational from the address |
| irq_o | output | 1 | Masked OR of the pending flags |

## Verification
The hardest thing to observe from the ports is the exact timing of the synchroniser. The counter is always moving, so the bench cannot just read it at leisure. For the stop latency, the bench samples the counter on the same falling edge that it presents the disabling write. It then expects exactly three further decrements. For the start latency, it combines reload with run and reads on every falling edge. It expects the reloaded value to hold for two edges before the first step. The one-shot parking and the 64-bit borrow are reached by programming tiny intervals. The borrow case uses a high word of one, so that the low word wraps within a few clocks.

// File: rtl/hst_pkg.sv
package hst_pkg;
  localparam int BUS_W   = 32;
  localparam int CNT_W   = 2 * BUS_W;
  localparam int PRESC_W = 3;

  // Register offsets relative to a channel's block
  localparam int CH_BASE   = 'h10;
  localparam int CH_STRIDE = 'h20;
  localparam int OFS_CTRL  = 'h00;
  localparam int OFS_IVLO  = 'h04;
  localparam int OFS_IVHI  = 'h08;
  localparam int OFS_CNLO  = 'h0C;
  localparam int OFS_CNHI  = 'h10;

  localparam int ADR_MASK  = 'h00;
  localparam int ADR_PEND  = 'h04;

  // Control word bit positions
  localparam int CB_RUN    = 0;
  localparam int CB_LOAD   = 1;
  localparam int CB_PSLO   = 4;
  localparam int CB_ONCE   = 7;

  typedef struct packed {
    logic               once;
    logic [PRESC_W-1:0] psel;
    logic               run;
  } ch_ctrl_t;
endpackage

// File: rtl/hst_prescaler.sv
module hst_prescaler #(
  parameter int PRESC_W = 3
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               run_i,
  input  logic               clear_i,
  input  logic [PRESC_W-1:0] sel_i,
  output logic               tick_o
);
  localparam int DIV_W = (1 << PRESC_W) - 1;

  logic [DIV_W-1:0] div_q, div_d;
  logic [DIV_W-1:0] mask;

  always_comb begin
    mask   = DIV_W'((32'd1 << sel_i) - 32'd1);
    tick_o = run_i && ((div_q & mask) == mask);
    div_d  = div_q;
    if (clear_i)    div_d = '0;
    else if (run_i) div_d = div_q + DIV_W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) div_q <= '0;
    else        div_q <= div_d;
  end

  // R6: back-to-back steps only occur with no division
  presc_spacing_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tick_o && $past(tick_o) && !$past(clear_i)) |-> (sel_i == '0));
endmodule

// File: rtl/hst_channel.sv
module hst_channel
  import hst_pkg::*;
#(
  parameter int W  = CNT_W,
  parameter int PW = PRESC_W
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          run_i,
  input  logic          once_i,
  input  logic [PW-1:0] psel_i,
  input  logic          load_i,
  input  logic [W-1:0]  interval_i,
  output logic [W-1:0]  count_o,
  output logic          expire_o
);
  logic         en_meta_q, en_sync_q;
  logic         parked_q, parked_d;
  logic [W-1:0] count_q, count_d;
  logic         active, step;

  assign active = en_sync_q && !parked_q;

  hst_prescaler #(.PRESC_W(PW)) u_presc (
    .clk     (clk),
    .rst_n   (rst_n),
    .run_i   (active),
    .clear_i (load_i),
    .sel_i   (psel_i),
    .tick_o  (step)
  );

  always_comb begin
    expire_o = step && (count_q == '0) && !load_i;
    count_d  = count_q;
    parked_d = parked_q;
    if (load_i) begin
      count_d  = interval_i;
      parked_d = 1'b0;
    end else if (expire_o) begin
      if (once_i) parked_d = 1'b1;
      else        count_d  = interval_i;
    end else if (step) begin
      count_d = count_q - W'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_meta_q <= 1'b0;
      en_sync_q <= 1'b0;
      parked_q  <= 1'b0;
      count_q   <= '0;
    end else begin
      en_meta_q <= run_i;
      en_sync_q <= en_meta_q;
      parked_q  <= parked_d;
      count_q   <= count_d;
    end
  end

  assign count_o = count_q;

  // R4
  frozen_when_unsynced_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!en_sync_q && !load_i) |=> $stable(count_q));
  // R3
  load_copy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    load_i |=> (count_q == $past(interval_i)));
  // R7
  periodic_reload_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (expire_o && !once_i) |=> (count_q == $past(interval_i)));
  // R8
  oneshot_park_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (parked_q && !load_i) |=> ($stable(count_q) && !expire_o));
endmodule

// File: rtl/hs_down_timer.sv
module hs_down_timer
  import hst_pkg::*;
#(
  parameter int NUM_CH = 2,
  parameter int ADDR_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] bus_addr_i,
  input  logic              bus_we_i,
  input  logic [31:0]       bus_wdata_i,
  output logic [31:0]       bus_rdata_o,
  output logic              irq_o
);
  localparam logic [ADDR_W-1:0] A_MASK = ADDR_W'(ADR_MASK);
  localparam logic [ADDR_W-1:0] A_PEND = ADDR_W'(ADR_PEND);

  logic [NUM_CH-1:0] mask_q, mask_d;
  logic [NUM_CH-1:0] pend_q, pend_d;
  logic [NUM_CH-1:0] expire_vec;
  logic [NUM_CH-1:0] pend_clr;
  logic [31:0]       rd_ch [NUM_CH];
  logic              pend_wr;

  assign pend_wr  = bus_we_i && (bus_addr_i == A_PEND);
  assign pend_clr = pend_wr ? bus_wdata_i[NUM_CH-1:0] : '0;

  for (genvar i = 0; i < NUM_CH; i++) begin : g_ch
    localparam int BASE = CH_BASE + CH_STRIDE * i;
    localparam logic [ADDR_W-1:0] A_CTRL = ADDR_W'(BASE + OFS_CTRL);
    localparam logic [ADDR_W-1:0] A_IVLO = ADDR_W'(BASE + OFS_IVLO);
    localparam logic [ADDR_W-1:0] A_IVHI = ADDR_W'(BASE + OFS_IVHI);
    localparam logic [ADDR_W-1:0] A_CNLO = ADDR_W'(BASE + OFS_CNLO);
    localparam logic [ADDR_W-1:0] A_CNHI = ADDR_W'(BASE + OFS_CNHI);

    ch_ctrl_t         ctrl_q, ctrl_d;
    logic [CNT_W-1:0] ivl_q, ivl_d;
    logic [CNT_W-1:0] count;
    logic             wr_ctrl, load;

    assign wr_ctrl = bus_we_i && (bus_addr_i == A_CTRL);
    assign load    = wr_ctrl && bus_wdata_i[CB_LOAD];

    always_comb begin
      ctrl_d = ctrl_q;
      ivl_d  = ivl_q;
      if (wr_ctrl) begin
        ctrl_d.run  = bus_wdata_i[CB_RUN];
        ctrl_d.psel = bus_wdata_i[CB_PSLO +: PRESC_W];
        ctrl_d.once = bus_wdata_i[CB_ONCE];
      end
      if (bus_we_i && bus_addr_i == A_IVLO) ivl_d[BUS_W-1:0]     = bus_wdata_i;
      if (bus_we_i && bus_addr_i == A_IVHI) ivl_d[CNT_W-1:BUS_W] = bus_wdata_i;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        ctrl_q <= '0;
        ivl_q  <= '0;
      end else begin
        ctrl_q <= ctrl_d;
        ivl_q  <= ivl_d;
      end
    end

    hst_channel u_chan (
      .clk        (clk),
      .rst_n      (rst_n),
      .run_i      (ctrl_q.run),
      .once_i     (ctrl_q.once),
      .psel_i     (ctrl_q.psel),
      .load_i     (load),
      .interval_i (ivl_q),
      .count_o    (count),
      .expire_o   (expire_vec[i])
    );

    always_comb begin
      rd_ch[i] = '0;
      unique case (bus_addr_i)
        A_CTRL: begin
          rd_ch[i][CB_RUN]               = ctrl_q.run;
          rd_ch[i][CB_PSLO +: PRESC_W]   = ctrl_q.psel;
          rd_ch[i][CB_ONCE]              = ctrl_q.once;
        end
        A_IVLO:  rd_ch[i] = ivl_q[BUS_W-1:0];
        A_IVHI:  rd_ch[i] = ivl_q[CNT_W-1:BUS_W];
        A_CNLO:  rd_ch[i] = count[BUS_W-1:0];
        A_CNHI:  rd_ch[i] = count[CNT_W-1:BUS_W];
        default: rd_ch[i] = '0;
      endcase
    end

    // R9
    pend_source_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(pend_q[i]) |-> $past(expire_vec[i]));
    // R9
    pend_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (pend_clr[i] && !expire_vec[i]) |=> !pend_q[i]);
  end

  always_comb begin
    mask_d = mask_q;
    if (bus_we_i && bus_addr_i == A_MASK) mask_d = bus_wdata_i[NUM_CH-1:0];
    pend_d = (pend_q & ~pend_clr) | expire_vec;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mask_q <= '0;
      pend_q <= '0;
    end else begin
      mask_q <= mask_d;
      pend_q <= pend_d;
    end
  end

  always_comb begin
    bus_rdata_o = '0;
    if (bus_addr_i == A_MASK) bus_rdata_o[NUM_CH-1:0] = mask_q;
    if (bus_addr_i == A_PEND) bus_rdata_o[NUM_CH-1:0] = pend_q;
    for (int i = 0; i < NUM_CH; i++) bus_rdata_o = bus_rdata_o | rd_ch[i];
  end

  assign irq_o = |(pend_q & mask_q);

  // R10: a masked-off pending flag alone never raises the line
  irq_masked_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mask_q == '0) |-> !irq_o);
endmodule

// File: tb/hs_down_timer_bench.sv
module hs_down_timer_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [7:0]  addr = '0;
  logic        we = 1'b0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic        irq;
  int checks = 0;
  int errors = 0;
  bit finished = 0;

  always #2 clk = ~clk;

  hs_down_timer u_hs_down_timer (
    .clk(clk), .rst_n(rst_n), .bus_addr_i(addr), .bus_we_i(we),
    .bus_wdata_i(wdata), .bus_rdata_o(rdata), .irq_o(irq)
  );

  localparam logic [7:0] MASK = 8'h00, PEND = 8'h04;
  function automatic logic [7:0] ra(int ch, int ofs);
    return 8'(16 + 32 * ch + ofs);
  endfunction
  function automatic logic [31:0] cw(bit run, bit ld, int p, bit once);
    return {24'b0, once, 3'(p), 2'b00, ld, run};
  endfunction

  task automatic chk(string req, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(logic [7:0] a, logic [31:0] d);
    @(negedge clk); addr = a; wdata = d; we = 1'b1;
    @(negedge clk); we = 1'b0;
  endtask

  task automatic rd(logic [7:0] a, output logic [31:0] d);
    addr = a; #1; d = rdata;
  endtask

  task automatic quiesce();
    wr(ra(0, 0), 0); wr(ra(1, 0), 0);
    repeat (4) @(negedge clk);
    wr(PEND, 32'h3);
  endtask

  task automatic t_reset();
    logic [31:0] v;
    for (int a = 0; a < 'h44; a += 4) begin
      rd(8'(a), v); chk("R1 reg zero", v, 0);
    end
    chk("R1 irq low", irq, 0);
  endtask

  task automatic t_ctrl_map();
    logic [31:0] v;
    wr(ra(1, 4), 32'hA5A5_0001); wr(ra(1, 8), 32'h0000_0002);
    wr(ra(1, 0), cw(0, 1, 5, 1));
    rd(ra(1, 0), v);  chk("R2 ctrl readback, reload reads 0", v, 32'hD0);
    rd(ra(1, 12), v); chk("R3 load low word", v, 32'hA5A5_0001);
    rd(ra(1, 16), v); chk("R3 load high word", v, 2);
    rd(ra(0, 12), v); chk("R2 other channel untouched", v, 0);
    quiesce();
  endtask

  task automatic t_start_stop();
    logic [31:0] v, c;
    wr(ra(0, 4), 100); wr(ra(0, 8), 0);
    wr(ra(0, 0), cw(1, 1, 0, 0));
    rd(ra(0, 12), v); chk("R3 loaded at write edge", v, 100);
    @(negedge clk); @(negedge clk);
    rd(ra(0, 12), v); chk("R4 no step before edge k+3", v, 100);
    @(negedge clk);
    rd(ra(0, 12), v); chk("R4 first step on edge k+3", v, 99);
    repeat (5) @(negedge clk);
    @(negedge clk); addr = ra(0, 12); #1; c = rdata;
    addr = ra(0, 0); wdata = cw(0, 0, 0, 0); we = 1'b1;
    @(negedge clk); we = 1'b0;
    repeat (4) @(negedge clk);
    rd(ra(0, 12), v); chk("R4 exactly three steps after disable", v, c - 3);
    repeat (6) @(negedge clk);
    rd(ra(0, 12), v); chk("R4 frozen after sync", v, c - 3);
    quiesce();
  endtask

  task automatic t_borrow();
    logic [31:0] lo, hi;
    wr(ra(0, 4), 1); wr(ra(0, 8), 1);
    wr(ra(0, 0), cw(1, 1, 0, 0));
    repeat (8) @(negedge clk);
    wr(ra(0, 0), 0);
    repeat (4) @(negedge clk);
    rd(ra(0, 16), hi); chk("R5 borrow into high word", hi, 0);
    rd(ra(0, 12), lo); chk("R5 low word wrapped", lo > 32'hFFFF_FF00, 1);
    quiesce();
  endtask

  task automatic t_presc(int p, int span, int exp_steps);
    logic [31:0] a, b;
    wr(ra(0, 4), 100000); wr(ra(0, 8), 0);
    wr(ra(0, 0), cw(1, 1, p, 0));
    repeat (5) @(negedge clk);
    rd(ra(0, 12), a);
    repeat (span) @(negedge clk);
    rd(ra(0, 12), b);
    chk($sformatf("R6 prescaler p=%0d steps", p), a - b, exp_steps);
    quiesce();
  endtask

  task automatic t_periodic();
    logic [31:0] v, prev;
    bit over, reloaded;
    prev = 99; over = 0; reloaded = 0;
    wr(MASK, 1);
    wr(ra(0, 4), 4); wr(ra(0, 8), 0);
    wr(ra(0, 0), cw(1, 1, 0, 0));
    for (int n = 0; n < 30; n++) begin
      @(negedge clk); rd(ra(0, 12), v);
      if (v > 4) over = 1;
      if (prev == 0 && v == 4) reloaded = 1;
      prev = v;
    end
    chk("R7 counter bounded by interval", over, 0);
    chk("R7 reload after zero", reloaded, 1);
    rd(PEND, v); chk("R9 pending set by expiry", v, 1);
    chk("R10 irq raised", irq, 1);
    wr(ra(0, 0), 0); repeat (4) @(negedge clk);
    wr(PEND, 1);
    rd(PEND, v); chk("R9 write-one clears", v, 0);
    chk("R10 irq drops", irq, 0);
    quiesce();
  endtask

  task automatic t_oneshot();
    logic [31:0] v;
    wr(ra(0, 4), 3); wr(ra(0, 8), 0);
    wr(ra(0, 0), cw(1, 1, 0, 1));
    repeat (15) @(negedge clk);
    rd(ra(0, 12), v); chk("R8 parked at zero", v, 0);
    rd(PEND, v);      chk("R8 expiry flagged", v, 1);
    wr(PEND, 1);
    repeat (20) @(negedge clk);
    rd(PEND, v);      chk("R8 no further expiry", v, 0);
    rd(ra(0, 12), v); chk("R8 still parked", v, 0);
    wr(ra(0, 0), cw(1, 1, 0, 1));
    rd(ra(0, 12), v); chk("R3 reload releases one-shot", v, 3);
    repeat (10) @(negedge clk);
    rd(PEND, v);      chk("R8 re-armed expiry", v, 1);
    quiesce();
  endtask

  task automatic t_mask();
    logic [31:0] v;
    wr(MASK, 1);
    wr(ra(1, 4), 2); wr(ra(1, 8), 0);
    wr(ra(1, 0), cw(1, 1, 0, 1));
    repeat (12) @(negedge clk);
    rd(PEND, v); chk("R9 flag set while masked", v, 2);
    chk("R10 masked flag keeps irq low", irq, 0);
    wr(MASK, 3);
    chk("R10 unmask raises irq", irq, 1);
    wr(PEND, 1);
    rd(PEND, v); chk("R9 clear of other bit leaves flag", v, 2);
    wr(PEND, 2);
    rd(PEND, v); chk("R9 clear ch1", v, 0);
    chk("R10 irq low after clear", irq, 0);
    quiesce();
  endtask

  task automatic t_freerun();
    logic [31:0] a, b;
    wr(ra(0, 4), 32'hFFFF_FFFF); wr(ra(0, 8), 0);
    wr(ra(0, 0), cw(1, 1, 0, 0));
    repeat (6) @(negedge clk);
    rd(ra(0, 12), a);
    @(negedge clk); rd(ra(0, 12), b);
    chk("R11 one per clock", a - b, 1);
    chk("R11 near all ones", a > 32'hFFFF_FFF0, 1);
    quiesce();
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_ctrl_map();
    t_start_stop();
    t_borrow();
    t_presc(0, 40, 40);
    t_presc(2, 40, 10);
    t_presc(7, 256, 2);
    t_periodic();
    t_oneshot();
    t_mask();
    t_freerun();
    if (!finished) begin
      finished = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    #(200000 * 4);
    if (!finished) begin
      finished = 1;
      checks++; errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule